// File: doc/BRIEF.md
# Protocol-Based VLAN Ingress Classifier

This block assigns a VLAN ID and a priority to every Ethernet frame that enters a switch port. It sits after the header parser. For each frame it receives the parsed EtherType or length field, a flag that says whether an 802.1Q tag is present, the tag control information (TCI), and the number of the ingress port. Exactly two clock cycles later it returns one classification result with a valid strobe.

Each port has its own tag-handling switch. When the switch is on, a frame whose tag carries a nonzero VLAN ID keeps that tag. All other frames go to protocol classification: untagged frames, frames with a tag that holds VLAN ID zero (priority-tagged frames), and every frame on a port whose tag handling is off. Protocol classification compares the frame's EtherType with four programmable entries for that port. Each entry has an enable bit and its own VLAN ID and priority. The lowest-numbered enabled entry that matches wins. When no entry matches, the port's default VLAN ID and priority apply. A single write port loads both the entries and the per-port settings, and a write affects only frames whose header arrives in a later cycle.

Top module: `vlan_cls_top`

## Requirements
- R1: A header presented with `hdr_valid` high on clock edge k produces `res_valid` high in the cycle after edge k+1, for one cycle per header, with `res_port` equal to that header's `hdr_port`. The result is produced for every header, including back-to-back headers.
- R2: When the port's tag-enable bit is 1 and `hdr_tagged` is 1 with a nonzero TCI[11:0], the result is `res_vid`=TCI[11:0], `res_pri`=TCI[15:13], `res_src`=1 (tag), and `res_idx`=0.
- R3: When the port's tag-enable bit is 0, a tagged frame is classified exactly as an untagged frame with the same EtherType.
- R4: A tagged frame whose TCI[11:0] is 0 falls through to protocol classification and then to the port default, even when tagging is enabled. A result with `res_src`=1 never carries VLAN ID 0.
- R5: A frame not taken by R2 whose `hdr_etype` equals the EtherType of an enabled entry of its port gets that entry's VLAN ID and priority, with `res_src`=2 (protocol) and `res_idx` set to the entry index.
- R6: When several enabled entries match, the entry with the lowest index supplies the result.
- R7: An entry whose enable bit is 0 never matches, whatever its EtherType.
- R8: When no entry matches, the result is the port default VLAN ID and priority, with `res_src`=0 (port) and `res_idx`=0.
- R9: Writes use `cfg_we` together with `cfg_kind`. With `cfg_kind`=0, `cfg_wdata` loads entry `cfg_idx` of port `cfg_port` as follows: [15:0] EtherType, [27:16] VLAN ID, [30:28] priority, [31] enable. With `cfg_kind`=1, `cfg_wdata` loads the port settings as follows: [11:0] default VLAN ID, [14:12] default priority, [15] tag enable. A header in the same cycle as a write sees the old values, and a header in any later cycle sees the new values.
- R10: After reset, `res_valid` is 0, every entry is disabled, and every port has default VLAN ID 1, priority 0 and tagging disabled.
- R11: Tables are per port. A write to one port never changes how frames on another port are classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Parsed header present this cycle |
| hdr_port | input | PORT_W (2) | Ingress port of the header |
| hdr_etype | input | 16 | EtherType or length field |
| hdr_tagged | input | 1 | Frame carries an 802.1Q tag |
| hdr_tci | input | 16 | Tag control information (priority 15:13, VID 11:0) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PORT_W (2) | Port addressed by the write |
| cfg_kind | input | 1 | 0: protocol entry, 1: port settings |
| cfg_idx | input | IDX_W (2) | Entry index for protocol entry writes |
| cfg_wdata | input | 32 | Write data, layout per R9 |
| res_valid | output | 1 | Classification result valid |
| res_port | output | PORT_W (2) | Port of the classified frame |
| res_vid | output | 12 | Assigned VLAN ID |
| res_pri | output | 3 | Assigned priority |
| res_src | output | 2 | 0 port default, 1 tag, 2 protocol entry |
| res_idx | output | IDX_W (2) | Matching entry index when `res_src`=2 |

## Verification
The bench goes after four corner cases.
- Priority-tagged frames with tagging on: a design that trusts any tag would emit VLAN 0 instead of falling through.
- Tagged frames with tagging off: a design that ignores the switch would keep the frame's tag.
- Several enabled entries with the same EtherType, plus disabled entries that hold the matching EtherType: a wrong priority encoder would report a higher index, and a missing enable check would report an entry that should stay silent.
- Headers that coincide with a write, and headers on other ports: a design with the wrong write timing would apply the new values one cycle early or late, and one with bad address decoding would leak a write onto another port's traffic.

// File: rtl/vlan_cls_pkg.sv
package vlan_cls_pkg;

    localparam int VID_W   = 12;
    localparam int PRI_W   = 3;
    localparam int ETYPE_W = 16;
    localparam int TCI_W   = 16;
    localparam int CFG_W   = 32;

    // protocol entry, bit layout equals the write data layout
    typedef struct packed {
        logic               en;
        logic [PRI_W-1:0]   pri;
        logic [VID_W-1:0]   vid;
        logic [ETYPE_W-1:0] etype;
    } proto_ent_t;

    // port settings, bit layout equals the low half of the write data
    typedef struct packed {
        logic             tag_en;
        logic [PRI_W-1:0] pri;
        logic [VID_W-1:0] vid;
    } port_cfg_t;

    typedef enum logic [1:0] {
        SRC_PORT  = 2'd0,
        SRC_TAG   = 2'd1,
        SRC_PROTO = 2'd2
    } res_src_e;

    localparam port_cfg_t PORT_CFG_RST = '{tag_en: 1'b0, pri: '0, vid: 12'd1};

    function automatic logic [VID_W-1:0] tci_vid(input logic [TCI_W-1:0] tci);
        return tci[VID_W-1:0];
    endfunction

    function automatic logic [PRI_W-1:0] tci_pri(input logic [TCI_W-1:0] tci);
        return tci[TCI_W-1 -: PRI_W];
    endfunction

endpackage

// File: rtl/vlan_cls_table.sv
module vlan_cls_table
    import vlan_cls_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_ENT   = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int IDX_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [PORT_W-1:0]       cfg_port,
    input  logic                    cfg_kind,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic [CFG_W-1:0]        cfg_wdata,
    input  logic [PORT_W-1:0]       rd_port,
    output proto_ent_t [NUM_ENT-1:0] rd_ent,
    output port_cfg_t               rd_cfg
);

    proto_ent_t ent_q  [NUM_PORTS][NUM_ENT];
    port_cfg_t  pcfg_q [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic port_sel;
        assign port_sel = cfg_we && (cfg_port == PORT_W'(p));

        for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q[p][e] <= '0;
                end else if (port_sel && !cfg_kind && cfg_idx == IDX_W'(e)) begin
                    ent_q[p][e] <= proto_ent_t'(cfg_wdata);
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pcfg_q[p] <= PORT_CFG_RST;
            end else if (port_sel && cfg_kind) begin
                pcfg_q[p] <= port_cfg_t'(cfg_wdata[$bits(port_cfg_t)-1:0]);
            end
        end
    end

    always_comb begin
        rd_cfg = PORT_CFG_RST;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_port == PORT_W'(p)) rd_cfg = pcfg_q[p];
        end
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_rd
        always_comb begin
            rd_ent[e] = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (rd_port == PORT_W'(p)) rd_ent[e] = ent_q[p][e];
            end
        end
    end

    // R10: every entry is disabled coming out of reset
    a_r10_reset_disabled: assert property (@(posedge clk)
        rst |=> !rd_ent[0].en);

endmodule

// File: rtl/vlan_cls_match.sv
module vlan_cls_match
    import vlan_cls_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  proto_ent_t [NUM_ENT-1:0] ent,
    input  logic [ETYPE_W-1:0]       etype,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx,
    output logic [VID_W-1:0]         hit_vid,
    output logic [PRI_W-1:0]         hit_pri
);

    logic [NUM_ENT-1:0] cmp;
    logic [NUM_ENT-1:0] first_oh;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
        assign cmp[e] = ent[e].en && (ent[e].etype == etype);
    end

    // isolate lowest set bit
    assign first_oh = cmp & (~cmp + NUM_ENT'(1));

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_vid = '0;
        hit_pri = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--) begin
            if (cmp[e]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(e);
                hit_vid = ent[e].vid;
                hit_pri = ent[e].pri;
            end
        end
    end

    // R6: the reported index agrees with the isolated lowest match
    always_comb begin
        a_r6_lowest_wins: assert (!hit || first_oh[hit_idx]);
    end

    // R7: the chosen entry is always an enabled one
    always_comb begin
        a_r7_enabled_only: assert (!hit || ent[hit_idx].en);
    end

endmodule

// File: rtl/vlan_cls_resolve.sv
module vlan_cls_resolve
    import vlan_cls_pkg::*;
#(
    parameter int PORT_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s1_valid,
    input  logic [PORT_W-1:0] s1_port,
    input  logic              s1_tag_use,
    input  logic [TCI_W-1:0]  s1_tci,
    input  logic              s1_hit,
    input  logic [IDX_W-1:0]  s1_idx,
    input  logic [VID_W-1:0]  s1_hvid,
    input  logic [PRI_W-1:0]  s1_hpri,
    input  logic [VID_W-1:0]  s1_dvid,
    input  logic [PRI_W-1:0]  s1_dpri,
    output logic              res_valid,
    output logic [PORT_W-1:0] res_port,
    output logic [VID_W-1:0]  res_vid,
    output logic [PRI_W-1:0]  res_pri,
    output res_src_e          res_src,
    output logic [IDX_W-1:0]  res_idx
);

    logic [VID_W-1:0] vid_d;
    logic [PRI_W-1:0] pri_d;
    res_src_e         src_d;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        if (s1_tag_use) begin
            vid_d = tci_vid(s1_tci);
            pri_d = tci_pri(s1_tci);
            src_d = SRC_TAG;
            idx_d = '0;
        end else if (s1_hit) begin
            vid_d = s1_hvid;
            pri_d = s1_hpri;
            src_d = SRC_PROTO;
            idx_d = s1_idx;
        end else begin
            vid_d = s1_dvid;
            pri_d = s1_dpri;
            src_d = SRC_PORT;
            idx_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_port  <= '0;
            res_vid   <= '0;
            res_pri   <= '0;
            res_src   <= SRC_PORT;
            res_idx   <= '0;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid) begin
                res_port <= s1_port;
                res_vid  <= vid_d;
                res_pri  <= pri_d;
                res_src  <= src_d;
                res_idx  <= idx_d;
            end
        end
    end

    // R4: a tag-sourced result never carries VLAN ID zero
    a_r4_tag_vid_nonzero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_src == SRC_TAG) |-> (res_vid != '0));

    // R8: index is zero unless a protocol entry supplied the result
    a_r8_idx_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_src != SRC_PROTO) |-> (res_idx == '0));

endmodule

// File: rtl/vlan_cls_top.sv
module vlan_cls_top
    import vlan_cls_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_ENT   = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int IDX_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hdr_valid,
    input  logic [PORT_W-1:0]   hdr_port,
    input  logic [ETYPE_W-1:0]  hdr_etype,
    input  logic                hdr_tagged,
    input  logic [TCI_W-1:0]    hdr_tci,
    input  logic                cfg_we,
    input  logic [PORT_W-1:0]   cfg_port,
    input  logic                cfg_kind,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic                res_valid,
    output logic [PORT_W-1:0]   res_port,
    output logic [VID_W-1:0]    res_vid,
    output logic [PRI_W-1:0]    res_pri,
    output logic [1:0]          res_src,
    output logic [IDX_W-1:0]    res_idx
);

    proto_ent_t [NUM_ENT-1:0] rd_ent;
    port_cfg_t                rd_cfg;
    logic                     m_hit;
    logic [IDX_W-1:0]         m_idx;
    logic [VID_W-1:0]         m_vid;
    logic [PRI_W-1:0]         m_pri;
    logic                     tag_use;

    vlan_cls_table #(.NUM_PORTS(NUM_PORTS), .NUM_ENT(NUM_ENT)) u_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_port  (cfg_port),
        .cfg_kind  (cfg_kind),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .rd_port   (hdr_port),
        .rd_ent    (rd_ent),
        .rd_cfg    (rd_cfg)
    );

    vlan_cls_match #(.NUM_ENT(NUM_ENT)) u_match (
        .ent     (rd_ent),
        .etype   (hdr_etype),
        .hit     (m_hit),
        .hit_idx (m_idx),
        .hit_vid (m_vid),
        .hit_pri (m_pri)
    );

    assign tag_use = rd_cfg.tag_en && hdr_tagged && (tci_vid(hdr_tci) != '0);

    // stage 1: header plus table lookup
    logic              s1_valid;
    logic [PORT_W-1:0] s1_port;
    logic              s1_tag_use;
    logic [TCI_W-1:0]  s1_tci;
    logic              s1_hit;
    logic [IDX_W-1:0]  s1_idx;
    logic [VID_W-1:0]  s1_hvid;
    logic [PRI_W-1:0]  s1_hpri;
    logic [VID_W-1:0]  s1_dvid;
    logic [PRI_W-1:0]  s1_dpri;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_port    <= '0;
            s1_tag_use <= 1'b0;
            s1_tci     <= '0;
            s1_hit     <= 1'b0;
            s1_idx     <= '0;
            s1_hvid    <= '0;
            s1_hpri    <= '0;
            s1_dvid    <= '0;
            s1_dpri    <= '0;
        end else begin
            s1_valid <= hdr_valid;
            if (hdr_valid) begin
                s1_port    <= hdr_port;
                s1_tag_use <= tag_use;
                s1_tci     <= hdr_tci;
                s1_hit     <= m_hit;
                s1_idx     <= m_idx;
                s1_hvid    <= m_vid;
                s1_hpri    <= m_pri;
                s1_dvid    <= rd_cfg.vid;
                s1_dpri    <= rd_cfg.pri;
            end
        end
    end

    res_src_e src_w;

    vlan_cls_resolve #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_resolve (
        .clk        (clk),
        .rst        (rst),
        .s1_valid   (s1_valid),
        .s1_port    (s1_port),
        .s1_tag_use (s1_tag_use),
        .s1_tci     (s1_tci),
        .s1_hit     (s1_hit),
        .s1_idx     (s1_idx),
        .s1_hvid    (s1_hvid),
        .s1_hpri    (s1_hpri),
        .s1_dvid    (s1_dvid),
        .s1_dpri    (s1_dpri),
        .res_valid  (res_valid),
        .res_port   (res_port),
        .res_vid    (res_vid),
        .res_pri    (res_pri),
        .res_src    (src_w),
        .res_idx    (res_idx)
    );

    assign res_src = src_w;

    // cycles since reset release, saturating
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R1: fixed two-cycle latency, one result per header
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (res_valid == $past(hdr_valid, 2)));

    // R1: the result carries the port of its header
    a_r1_port: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2 && res_valid) |-> (res_port == $past(hdr_port, 2)));

    // R10: no result straight out of reset
    a_r10_idle_after_reset: assert property (@(posedge clk)
        rst |=> !res_valid);

endmodule

// File: tb/vlan_cls_top_tb_top.sv
module vlan_cls_top_tb_top;

    localparam int NP = 4;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_valid = 1'b0;
    logic [1:0]  hdr_port = '0;
    logic [15:0] hdr_etype = '0;
    logic        hdr_tagged = 1'b0;
    logic [15:0] hdr_tci = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_port = '0;
    logic        cfg_kind = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        res_valid;
    logic [1:0]  res_port;
    logic [11:0] res_vid;
    logic [2:0]  res_pri;
    logic [1:0]  res_src;
    logic [1:0]  res_idx;

    always #5 clk = ~clk;

    vlan_cls_top dut_i (
        .clk(clk), .rst(rst),
        .hdr_valid(hdr_valid), .hdr_port(hdr_port), .hdr_etype(hdr_etype),
        .hdr_tagged(hdr_tagged), .hdr_tci(hdr_tci),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .res_valid(res_valid), .res_port(res_port), .res_vid(res_vid),
        .res_pri(res_pri), .res_src(res_src), .res_idx(res_idx)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference tables
    int m_en [NP][NE];
    int m_et [NP][NE];
    int m_vid[NP][NE];
    int m_pri[NP][NE];
    int d_vid[NP];
    int d_pri[NP];
    int d_tag[NP];

    typedef struct {
        bit    v;
        int    port, vid, pri, src, idx;
        string req;
    } exp_t;

    exp_t q[$];

    // stimulus for the next tick
    bit    n_hv;  int n_port; int n_et; bit n_tag; int n_tci;
    bit    n_we;  int n_cport; bit n_kind; int n_cidx; logic [31:0] n_wd;
    string n_req;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            for (int e = 0; e < NE; e++) begin
                m_en[p][e] = 0; m_et[p][e] = 0; m_vid[p][e] = 0; m_pri[p][e] = 0;
            end
            d_vid[p] = 1; d_pri[p] = 0; d_tag[p] = 0;
        end
    endtask

    function automatic exp_t predict(int p, int et, bit tg, int tci);
        exp_t r;
        r.v = 1; r.port = p; r.idx = 0;
        if (d_tag[p] != 0 && tg && (tci & 12'hFFF) != 0) begin
            r.vid = tci & 12'hFFF; r.pri = (tci >> 13) & 7; r.src = 1; r.req = "R2";
            return r;
        end
        for (int e = 0; e < NE; e++) begin
            if (m_en[p][e] != 0 && m_et[p][e] == et) begin
                r.vid = m_vid[p][e]; r.pri = m_pri[p][e]; r.src = 2; r.idx = e;
                r.req = "R5";
                return r;
            end
        end
        r.vid = d_vid[p]; r.pri = d_pri[p]; r.src = 0; r.req = "R8";
        return r;
    endfunction

    task automatic clear_next();
        n_hv = 0; n_port = 0; n_et = 0; n_tag = 0; n_tci = 0;
        n_we = 0; n_cport = 0; n_kind = 0; n_cidx = 0; n_wd = '0; n_req = "";
    endtask

    task automatic tick();
        exp_t e;
        @(negedge clk);
        if (q.size() == 2) begin
            e = q.pop_front();
            chk(res_valid == e.v, (e.req == "") ? "R1" : e.req, "res_valid",
                int'(res_valid), int'(e.v));
            if (e.v && res_valid) begin
                chk(int'(res_port) == e.port, "R1", "res_port", int'(res_port), e.port);
                chk(int'(res_vid) == e.vid, e.req, "res_vid", int'(res_vid), e.vid);
                chk(int'(res_pri) == e.pri, e.req, "res_pri", int'(res_pri), e.pri);
                chk(int'(res_src) == e.src, e.req, "res_src", int'(res_src), e.src);
                chk(int'(res_idx) == e.idx, e.req, "res_idx", int'(res_idx), e.idx);
            end
        end
        hdr_valid  = n_hv;
        hdr_port   = 2'(n_port);
        hdr_etype  = 16'(n_et);
        hdr_tagged = n_tag;
        hdr_tci    = 16'(n_tci);
        cfg_we     = n_we;
        cfg_port   = 2'(n_cport);
        cfg_kind   = n_kind;
        cfg_idx    = 2'(n_cidx);
        cfg_wdata  = n_wd;
        if (n_hv) begin
            e = predict(n_port, n_et, n_tag, n_tci);
            if (n_req != "") e.req = n_req;
        end else begin
            e.v = 0; e.port = 0; e.vid = 0; e.pri = 0; e.src = 0; e.idx = 0; e.req = n_req;
        end
        q.push_back(e);
        // model write applies after this cycle's header (R9)
        if (n_we) begin
            if (!n_kind) begin
                m_et [n_cport][n_cidx] = int'(n_wd[15:0]);
                m_vid[n_cport][n_cidx] = int'(n_wd[27:16]);
                m_pri[n_cport][n_cidx] = int'(n_wd[30:28]);
                m_en [n_cport][n_cidx] = int'(n_wd[31]);
            end else begin
                d_vid[n_cport] = int'(n_wd[11:0]);
                d_pri[n_cport] = int'(n_wd[14:12]);
                d_tag[n_cport] = int'(n_wd[15]);
            end
        end
        clear_next();
    endtask

    task automatic wr_ent(int p, int i, bit en, int pri, int vid, int et);
        n_we = 1; n_cport = p; n_kind = 0; n_cidx = i;
        n_wd = {en, 3'(pri), 12'(vid), 16'(et)};
        tick();
    endtask

    task automatic wr_port(int p, bit tg, int pri, int vid);
        n_we = 1; n_cport = p; n_kind = 1;
        n_wd = {16'h0, tg, 3'(pri), 12'(vid)};
        tick();
    endtask

    task automatic hdr(int p, int et, bit tg, int tci, string req);
        n_hv = 1; n_port = p; n_et = et; n_tag = tg; n_tci = tci; n_req = req;
        tick();
    endtask

    initial begin
        model_reset();
        clear_next();
        repeat (3) @(negedge clk);
        // R10: idle during reset
        chk(res_valid == 1'b0, "R10", "res_valid in reset", int'(res_valid), 0);
        rst = 1'b0;

        // R10: defaults after reset (VID 1, prio 0, tagging off, no entries)
        hdr(0, 16'h0800, 0, 0, "R10");
        hdr(3, 16'h86DD, 1, 16'hA123, "R10");

        // configure port 0 and 1
        wr_port(0, 1, 5, 100);
        wr_port(1, 0, 2, 200);
        wr_ent(0, 0, 1, 1, 10, 16'h0800);
        wr_ent(0, 1, 1, 2, 11, 16'h86DD);
        wr_ent(0, 3, 1, 4, 13, 16'h86DD);
        wr_ent(0, 2, 0, 3, 12, 16'h8137);
        tick();

        hdr(0, 16'h0800, 0, 0, "R5");
        hdr(0, 16'h86DD, 0, 0, "R6");              // idx1 and idx3 match
        hdr(0, 16'h8137, 0, 0, "R7");              // disabled entry
        hdr(0, 16'h1234, 0, 0, "R8");
        hdr(0, 16'h0800, 1, 16'h6ABC, "R2");       // tag with tagging on
        hdr(0, 16'h0800, 1, 16'hE000, "R4");       // priority tag -> protocol
        hdr(0, 16'h4444, 1, 16'h2000, "R4");       // priority tag -> default
        hdr(1, 16'h0800, 1, 16'h6ABC, "R3");       // tagging off on port 1

        // R11: port 1 did not inherit port 0 entries; write to port 2 leaves port 1
        wr_ent(2, 0, 1, 6, 77, 16'h0800);
        hdr(1, 16'h0800, 0, 0, "R11");
        hdr(1, 16'h86DD, 0, 0, "R11");

        // R9: header in the same cycle as a write sees old, next cycle new
        n_we = 1; n_cport = 1; n_kind = 0; n_cidx = 0;
        n_wd = {1'b1, 3'd7, 12'd999, 16'h0800};
        n_hv = 1; n_port = 1; n_et = 16'h0800; n_req = "R9";
        tick();
        hdr(1, 16'h0800, 0, 0, "R9");
        // disable an entry and see it stop matching
        wr_ent(1, 0, 0, 7, 999, 16'h0800);
        hdr(1, 16'h0800, 0, 0, "R7");
        // port settings write timing
        n_we = 1; n_cport = 1; n_kind = 1; n_wd = {16'h0, 1'b1, 3'd3, 12'd55};
        n_hv = 1; n_port = 1; n_et = 16'h0800; n_tag = 1; n_tci = 16'h4321; n_req = "R9";
        tick();
        hdr(1, 16'h0800, 1, 16'h4321, "R9");

        // R1: back-to-back headers across ports
        for (int i = 0; i < 8; i++) hdr(i % NP, 16'h0800, 0, 0, "R1");
        tick();

        // random mixed traffic and writes
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 2) begin
                n_we = 1; n_cport = $urandom_range(0, NP - 1);
                n_kind = $urandom_range(0, 1); n_cidx = $urandom_range(0, NE - 1);
                n_wd = $urandom();
                n_wd[15:0] = 16'(16'h0800 + $urandom_range(0, 3));
            end
            if (r != 9) begin
                n_hv = 1; n_port = $urandom_range(0, NP - 1);
                n_et = 16'h0800 + $urandom_range(0, 4);
                n_tag = $urandom_range(0, 1);
                n_tci = $urandom_range(0, 3) == 0 ? ($urandom() & 16'hE000) : ($urandom() & 16'hFFFF);
            end
            tick();
        end
        tick(); tick(); tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule